// File: doc/BRIEF.md
# Split Serial Access Memory Controller

This block is the serial side of a dual-port frame memory. It keeps a static register of 512 words of 16 bits. An address pointer walks through the register one word per clock while the serial enable is high. In output mode the addressed word is driven on a bidirectional data port. In input mode the word on that port is written into the addressed word. A transfer-cycle strobe moves whole rows, or half rows, between a wide row bus and the register. The same strobe sets the pointer start (the tap) and decides the serial direction for the cycles that follow.

The register can run as one 512-word ring. It can also run as two 256-word halves that work on their own. In split operation, a half-row transfer reaches only the half the pointer is not in, so that half can be refilled while the active half keeps shifting. The tap carried by that transfer is held back. The pointer jumps to it only when it runs off the end of the active half. A half flag shows which half holds the pointer. The array behind the row bus and its timing are outside this block.

Top module: `serial_frame_buffer`

## Requirements
- R1: While reset is low and after it is released, the pointer is word 0, `half_hi` is 0, the block is in non-split operation and in output mode, and `sdq_oe` is 0 while `ser_en` is 0.
- R2: A transfer with `xfer_go`=1, `xfer_kind`=2'b00 (read) and `xfer_split`=0 loads every word from `row_in` and sets the pointer to `xfer_tap`. Word i sits at `row_in[i*16 +: 16]`. The block then leaves split operation.
- R3: While `ser_en` is 1 and no transfer occurs, the pointer advances by one word per clock. While `ser_en` is 0 it holds. In output mode `sdq` carries the word the pointer addresses.
- R4: In non-split operation, the word after word 511 is word 0.
- R5: A transfer with `xfer_split`=1 enters split operation and stores the low 8 bits of `xfer_tap` as the pending tap. If the kind is read, it loads only the half the pointer is not in, and the active half is left unchanged.
- R6: In split operation the pointer never leaves its half, except after word 255 or word 511. After either of those it moves to the pending tap inside the other half.
- R7: `half_hi` is 1 exactly when the pointer is in words 256 to 511.
- R8: A read transfer sets output mode. A write transfer (`xfer_kind`=2'b01) or a pseudo-write transfer (2'b10 or 2'b11) sets input mode. `sdq_oe` is 1 only in output mode with `ser_en`=1. Otherwise `sdq` is high impedance.
- R9: In input mode, with `ser_en`=1, the word on `sdq` is written into the addressed word. `row_out` always presents every word, with word i at bits i*16 +: 16.
- R10: Write and pseudo-write transfers leave the stored words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; every state change happens on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_en | input | 1 | Serial enable: steps the pointer and opens the data port |
| sdq | inout | 16 | Bidirectional serial data |
| sdq_oe | output | 1 | High while the block drives `sdq` |
| half_hi | output | 1 | High when the pointer is in the upper half |
| xfer_go | input | 1 | Transfer-cycle strobe, one clock wide |
| xfer_split | input | 1 | Selects a half-row transfer |
| xfer_kind | input | 2 | 00 read, 01 write, 10/11 pseudo write |
| xfer_tap | input | 9 | Tap address carried by the transfer |
| row_in | input | 8192 | Row data for read transfers |
| row_out | output | 8192 | Current register contents for unloading |

## Verification
The checker assumes that `xfer_go` is a one-clock strobe. It also assumes that nothing outside drives `sdq` while `sdq_oe` is high, and that a half-row transfer never lands in the same clock as a boundary crossing. The bench meets all three. It pulses each transfer for a single clock with `ser_en` low. It drives `sdq` only in input mode. It issues half-row transfers only while the pointer is parked away from the end of its half. The bench walks the pointer over full rings and across both half boundaries, and keeps its own model of the stored words and of the pointer.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
   typedef enum logic [1:0] {
      XF_READ   = 2'b00,
      XF_WRITE  = 2'b01,
      XF_PSEUDO = 2'b10
   } xfer_kind_e;

   function automatic logic kind_is_read(input logic [1:0] kind);
      return kind == XF_READ;
   endfunction
endpackage

// File: rtl/sfb_pointer.sv
// Serial address pointer with ring and split (two-half) stepping.
module sfb_pointer #(
   parameter int AW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ser_en,
   input  logic          xfer_go,
   input  logic          xfer_split,
   input  logic [AW-1:0] xfer_tap,
   output logic [AW-1:0] ptr,
   output logic          split_on
);
   localparam int LW = AW - 1;

   logic [AW-1:0] ptr_q;
   logic          split_q;
   logic [LW-1:0] pend_q;
   logic          half_end;
   logic [LW-1:0] tap_lo;

   assign half_end = &ptr_q[LW-1:0];
   // a split transfer landing in this cycle supplies the newest tap
   assign tap_lo   = (xfer_go && xfer_split) ? xfer_tap[LW-1:0] : pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q   <= '0;
         split_q <= 1'b0;
         pend_q  <= '0;
      end else begin
         if (xfer_go && !xfer_split) begin
            ptr_q   <= xfer_tap;
            split_q <= 1'b0;
         end else if (ser_en) begin
            if (split_q && half_end)
               ptr_q <= {~ptr_q[AW-1], tap_lo};
            else
               ptr_q <= ptr_q + 1'b1;
         end
         if (xfer_go && xfer_split) begin
            split_q <= 1'b1;
            pend_q  <= xfer_tap[LW-1:0];
         end
      end
   end

   assign ptr      = ptr_q;
   assign split_on = split_q;
endmodule

// File: rtl/sfb_dirctl.sv
// Serial direction, set by the most recent transfer cycle.
module sfb_dirctl (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       xfer_go,
   input  logic [1:0] xfer_kind,
   output logic       out_mode
);
   import sfb_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         out_mode <= 1'b1;
      else if (xfer_go)
         out_mode <= kind_is_read(xfer_kind);
   end
endmodule

// File: rtl/sfb_store.sv
// Static word store: full or half parallel load, single-word serial write.
module sfb_store #(
   parameter int WORDS = 512,
   parameter int WIDTH = 16,
   parameter int AW    = 9
) (
   input  logic                   clk,
   input  logic                   load_all,
   input  logic                   load_half,
   input  logic                   half_sel,
   input  logic [WORDS*WIDTH-1:0] row_in,
   input  logic                   wr_en,
   input  logic [AW-1:0]          wr_addr,
   input  logic [WIDTH-1:0]       wr_data,
   input  logic [AW-1:0]          rd_addr,
   output logic [WIDTH-1:0]       rd_data,
   output logic [WORDS*WIDTH-1:0] row_out
);
   localparam int HALF = WORDS / 2;

   for (genvar i = 0; i < WORDS; i++) begin : g_word
      localparam bit UPPER = (i >= HALF);
      logic [WIDTH-1:0] word_q;
      logic             take_row;

      assign take_row = load_all || (load_half && (UPPER == half_sel));

      always_ff @(posedge clk) begin
         if (take_row)
            word_q <= row_in[i*WIDTH +: WIDTH];
         else if (wr_en && (wr_addr == AW'(i)))
            word_q <= wr_data;
      end

      assign row_out[i*WIDTH +: WIDTH] = word_q;
   end

   assign rd_data = row_out[rd_addr*WIDTH +: WIDTH];
endmodule

// File: rtl/serial_frame_buffer.sv
// Serial side of a dual-port frame memory with split-half operation.
module serial_frame_buffer #(
   parameter int WORDS = 512,
   parameter int WIDTH = 16,
   localparam int AW   = $clog2(WORDS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   ser_en,
   inout  wire  [WIDTH-1:0]       sdq,
   output logic                   sdq_oe,
   output logic                   half_hi,
   input  logic                   xfer_go,
   input  logic                   xfer_split,
   input  logic [1:0]             xfer_kind,
   input  logic [AW-1:0]          xfer_tap,
   input  logic [WORDS*WIDTH-1:0] row_in,
   output logic [WORDS*WIDTH-1:0] row_out
);
   import sfb_pkg::*;

   if (WORDS < 4 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_words
      $error("serial_frame_buffer: WORDS must be a power of two of at least 4");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("serial_frame_buffer: WIDTH must be positive");
   end

   logic [AW-1:0]    ptr;
   logic             split_on;
   logic             out_mode;
   logic             is_read;
   logic [WIDTH-1:0] rd_data;

   assign is_read = kind_is_read(xfer_kind);

   sfb_pointer #(.AW(AW)) u_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .ser_en     (ser_en),
      .xfer_go    (xfer_go),
      .xfer_split (xfer_split),
      .xfer_tap   (xfer_tap),
      .ptr        (ptr),
      .split_on   (split_on)
   );

   sfb_dirctl u_dir (
      .clk       (clk),
      .rst_n     (rst_n),
      .xfer_go   (xfer_go),
      .xfer_kind (xfer_kind),
      .out_mode  (out_mode)
   );

   sfb_store #(.WORDS(WORDS), .WIDTH(WIDTH), .AW(AW)) u_store (
      .clk       (clk),
      .load_all  (xfer_go && is_read && !xfer_split),
      .load_half (xfer_go && is_read && xfer_split),
      .half_sel  (~ptr[AW-1]),
      .row_in    (row_in),
      .wr_en     (ser_en && !out_mode),
      .wr_addr   (ptr),
      .wr_data   (sdq),
      .rd_addr   (ptr),
      .rd_data   (rd_data),
      .row_out   (row_out)
   );

   assign sdq_oe  = out_mode && ser_en;
   assign half_hi = ptr[AW-1];
   assign sdq     = sdq_oe ? rd_data : 'z;
endmodule

// File: rtl/sfb_checker.sv
module sfb_checker #(
   parameter int AW = 9
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ser_en,
   input logic          xfer_go,
   input logic          xfer_split,
   input logic [1:0]    xfer_kind,
   input logic [AW-1:0] xfer_tap,
   input logic [AW-1:0] ptr,
   input logic          split_on,
   input logic          half_hi,
   input logic          sdq_oe
);
   // R1: pointer and half flag leave reset at word 0
   p_reset_state_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> (ptr == '0 && !half_hi && !split_on));

   // R2: full transfer places the pointer at the tap
   p_full_tap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_go && !xfer_split |=> ptr == $past(xfer_tap));

   // R3: pointer holds without serial enable
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !ser_en && !xfer_go |=> $stable(ptr));

   // R3/R4: single step, wrapping from the top word to word 0
   p_step_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ser_en && !xfer_go && !(split_on && (&ptr[AW-2:0]))
      |=> ptr == $past(ptr) + 1'b1);

   // R6: split operation stays inside the half until its last word
   p_stay_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
      split_on && ser_en && !xfer_go && !(&ptr[AW-2:0])
      |=> half_hi == $past(half_hi));

   // R6: last word of a half crosses to the other half
   p_cross_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
      split_on && ser_en && !xfer_go && (&ptr[AW-2:0])
      |=> half_hi != $past(half_hi));

   // R8: write or pseudo-write transfer releases the data port
   p_input_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_go && xfer_kind != 2'b00 |=> !sdq_oe);

   // R8: port is released while serial enable is low
   p_oe_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ser_en |-> !sdq_oe);
endmodule

bind serial_frame_buffer sfb_checker #(.AW(AW)) u_sfb_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .ser_en     (ser_en),
   .xfer_go    (xfer_go),
   .xfer_split (xfer_split),
   .xfer_kind  (xfer_kind),
   .xfer_tap   (xfer_tap),
   .ptr        (ptr),
   .split_on   (split_on),
   .half_hi    (half_hi),
   .sdq_oe     (sdq_oe)
);

// File: tb/test_serial_frame_buffer.sv
module test_serial_frame_buffer;
   localparam int WORDS = 512;
   localparam int WIDTH = 16;
   localparam int AW    = 9;
   localparam int HALF  = 256;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic                   rst_n;
   logic                   ser_en;
   logic                   xfer_go;
   logic                   xfer_split;
   logic [1:0]             xfer_kind;
   logic [AW-1:0]          xfer_tap;
   logic [WORDS*WIDTH-1:0] row_in;
   wire  [WORDS*WIDTH-1:0] row_out;
   wire  [WIDTH-1:0]       sdq;
   wire                    sdq_oe;
   wire                    half_hi;
   logic [WIDTH-1:0]       tb_drv;
   logic                   tb_oe;

   assign sdq = tb_oe ? tb_drv : 'z;

   serial_frame_buffer #(.WORDS(WORDS), .WIDTH(WIDTH)) i_serial_frame_buffer (
      .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .sdq(sdq), .sdq_oe(sdq_oe),
      .half_hi(half_hi), .xfer_go(xfer_go), .xfer_split(xfer_split),
      .xfer_kind(xfer_kind), .xfer_tap(xfer_tap), .row_in(row_in), .row_out(row_out)
   );

   int n_run = 0;
   int n_fail = 0;
   logic [WIDTH-1:0] model [WORDS];
   int  e_ptr = 0;
   bit  split_m = 1'b0;
   int  pend_m = 0;
   bit  done = 1'b0;

   function automatic logic [WIDTH-1:0] pat(input int seed, input int i);
      return WIDTH'((i * 40503 + seed * 7919) ^ (i << 7) ^ seed);
   endfunction

   function automatic int next_ptr(input int p);
      if (split_m && (p % HALF) == HALF - 1)
         return ((p >= HALF) ? 0 : HALF) + pend_m;
      return (p + 1) % WORDS;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic fill_row(input int seed);
      for (int i = 0; i < WORDS; i++) row_in[i*WIDTH +: WIDTH] = pat(seed, i);
   endtask

   task automatic do_xfer(input logic [1:0] kind, input bit split, input int tap, input int seed);
      @(negedge clk);
      fill_row(seed);
      xfer_kind  = kind;
      xfer_split = split;
      xfer_tap   = AW'(tap);
      xfer_go    = 1'b1;
      @(negedge clk);
      xfer_go = 1'b0;
      if (kind == 2'b00) begin
         for (int i = 0; i < WORDS; i++)
            if (!split || ((i >= HALF) != (e_ptr >= HALF))) model[i] = pat(seed, i);
      end
      if (split) begin
         split_m = 1'b1;
         pend_m  = tap % HALF;
      end else begin
         split_m = 1'b0;
         e_ptr   = tap;
      end
   endtask

   task automatic step_read(input int n, input string req);
      int bad = 0;
      int bad_act = 0;
      int bad_exp = 0;
      for (int k = 0; k < n; k++) begin
         ser_en = 1'b1;
         #1;
         if (sdq !== model[e_ptr] || half_hi !== (e_ptr >= HALF) || sdq_oe !== 1'b1) begin
            if (bad == 0) begin bad_act = int'(sdq); bad_exp = int'(model[e_ptr]); end
            bad++;
         end
         @(negedge clk);
         e_ptr = next_ptr(e_ptr);
      end
      ser_en = 1'b0;
      chk(bad == 0, req, "serial read word/half flag", bad_act, bad_exp);
   endtask

   task automatic step_write(input int n, input int seed);
      int bad = 0;
      for (int k = 0; k < n; k++) begin
         ser_en = 1'b1;
         tb_oe  = 1'b1;
         tb_drv = pat(seed, k);
         #1;
         if (sdq_oe !== 1'b0) bad++;
         @(negedge clk);
         model[e_ptr] = pat(seed, k);
         e_ptr = next_ptr(e_ptr);
      end
      ser_en = 1'b0;
      tb_oe  = 1'b0;
      chk(bad == 0, "R8", "port released in input mode", bad, 0);
   endtask

   task automatic check_row(input string req);
      int bad = 0;
      int first = -1;
      for (int i = 0; i < WORDS; i++)
         if (row_out[i*WIDTH +: WIDTH] !== model[i]) begin
            bad++;
            if (first < 0) first = i;
         end
      chk(bad == 0, req, "row_out mismatching words (first index in actual)", first, -1);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; ser_en = 1'b0; xfer_go = 1'b0; xfer_split = 1'b0;
      xfer_kind = 2'b00; xfer_tap = '0; row_in = '0; tb_drv = '0; tb_oe = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      chk(half_hi === 1'b0, "R1", "half flag in reset", int'(half_hi), 0);
      chk(sdq_oe === 1'b0, "R1", "port released in reset", int'(sdq_oe), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      ser_en = 1'b1;
      #1;
      chk(sdq_oe === 1'b1, "R1", "output mode after reset", int'(sdq_oe), 1);
      chk(half_hi === 1'b0, "R1", "pointer in lower half after reset", int'(half_hi), 0);
      ser_en = 1'b0;
      #1;
      chk(sdq_oe === 1'b0, "R8", "port released without enable", int'(sdq_oe), 0);

      // R2, R3, R4, R7: full read transfer near the top, full ring plus wrap
      do_xfer(2'b00, 1'b0, 500, 1);
      check_row("R2");
      step_read(520, "R4");

      // R3: hold while enable is low
      repeat (3) @(negedge clk);
      step_read(1, "R3");

      // second full transfer from a low tap
      do_xfer(2'b00, 1'b0, 250, 2);
      step_read(10, "R7");

      // R5: split read into the inactive (lower) half, pointer at 260
      do_xfer(2'b00, 1'b1, 10, 3);
      check_row("R5");
      // R6: run to 511, jump to 10, run to 255, jump to 266
      step_read(252 + 246 + 5, "R6");

      // R10: write transfer leaves the words alone, R8 input mode
      do_xfer(2'b01, 1'b0, 3, 4);
      check_row("R10");
      // R9: serial writes into words 3..10
      step_write(8, 5);
      check_row("R9");

      // R10: pseudo-write split transfer leaves the words alone
      do_xfer(2'b10, 1'b1, 5, 6);
      check_row("R10");
      step_write(1, 7);
      check_row("R9");

      // R8: read transfer restores output mode
      do_xfer(2'b00, 1'b0, 0, 8);
      step_read(4, "R8");
      check_row("R2");

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule